// File: doc/BRIEF.md
# System Control Register File

This block holds the system-control state of a processor core. It is reached through coprocessor move operations. Each access presents a 32-bit instruction word, a write strobe and, for writes, a data word. The block takes a primary register number from instruction bits [19:16] and a secondary selector from bits [7:5]. A read returns its data in the same cycle. A write is committed on the next rising clock edge.

Several register numbers hold more than one word, chosen by the selector. Reserved numbers and unsupported selectors raise an undefined-access flag that the core turns into an exception. Some writes also ask the memory system to discard cached translation state. The block signals these with one-cycle pulses: a TLB flush and a translation-cache flush. Reading the cache-operation register pulses a flag-clear output, which tells the core to clear its N and Z condition flags.

A model-select input is sampled during reset. It chooses the identification word, the floating-point identification word and whether the auxiliary control register exists.

Top module: `sysctl_regs`

## Requirements
- R1: On register 0, selector 1 reads 0x01DD20D2 and selector 2 reads zero. Every other selector reads the CPU identification word. Any write to register 0 is undefined.
- R2: While reset is high, the block loads the identity of the selected model. For model 0 that is CPU ID 0x4100A010, FP ID 0x41011090, no auxiliary register. For model 1 it is CPU ID 0x4100B020, FP ID 0x410110A0, with an auxiliary register. All writable registers clear to zero and all pulse outputs are low.
- R3: On register 1, selector 0 is the read/write control register and selector 2 is the read/write coprocessor-access register. Selector 1 reads 1 when the model has an auxiliary register; otherwise, and for any write, it is undefined. All other selectors are undefined.
- R4: A write to the control register raises tlb_flush for exactly the one cycle after the committing edge. A write to the coprocessor-access register does the same with tcache_flush.
- R5: Registers 2 and 3 are read/write words. The selector does not affect them.
- R6: Registers 5, 6 and 9 each hold two independent words, at selector 0 and selector 1. Every other selector is undefined.
- R7: A write to register 8 with selector 0 or 1 raises tlb_flush for one cycle and stores nothing. Other selectors, and every read of register 8, are undefined.
- R8: Register 13 holds the relocation word at selector 0 and the context word at selector 1; other selectors are undefined. A write to either raises tlb_flush only when the new value differs from the stored one.
- R9: Register numbers 4, 11, 12 and 14 are undefined for both reads and writes.
- R10: Registers 10 and 15 read zero and ignore writes. Register 7 ignores writes and reads zero, and a read of it raises flag_clr for the following cycle.
- R11: An undefined access leaves every register unchanged and raises no pulse.
- R12: Only bits [19:16] and [7:5] of the instruction word affect decoding. When acc_valid is low, undef is low and rd_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| model_sel | input | 1 | Model choice, sampled during reset |
| acc_valid | input | 1 | A coprocessor access is presented this cycle |
| acc_write | input | 1 | 1 = write (move to), 0 = read (move from) |
| acc_insn | input | 32 | Instruction word carrying register number and selector |
| wr_data | input | 32 | Data for a write |
| rd_data | output | 32 | Read data, combinational |
| undef | output | 1 | Current access is undefined |
| fp_id | output | 32 | Floating-point identification word of the model |
| tlb_flush | output | 1 | One-cycle TLB flush request |
| tcache_flush | output | 1 | One-cycle translation-cache flush request |
| flag_clr | output | 1 | One-cycle request to clear the N and Z flags |

## Verification
The main stimulus pattern is a walk over every register number. Each one is read and written under several selectors, which shows which numbers fold the selector away and which treat a stray selector as undefined. Register 13 is written with an unchanged value and then with a changed one, which separates the conditional flush from an unconditional one. Writes to paired registers use different data for each selector, which exposes crossed or shared storage. Undefined writes are followed by reads of the registers they could have touched, and instruction words with noise outside the two fields check that decoding ignores those bits.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned CRN_W   = 4;
    localparam int unsigned SEL_W   = 3;
    localparam int unsigned N_SLOTS = 12;
    localparam int unsigned SLOT_W  = $clog2(N_SLOTS);

    localparam logic [31:0] CACHE_TYPE_WORD = 32'h01DD_20D2;

    typedef logic [SLOT_W-1:0] slot_t;

    // storage slots of the writable registers
    localparam slot_t SL_CTRL  = slot_t'(0);
    localparam slot_t SL_CPACC = slot_t'(1);
    localparam slot_t SL_TTB   = slot_t'(2);
    localparam slot_t SL_DAC   = slot_t'(3);
    localparam slot_t SL_FSR_D = slot_t'(4);
    localparam slot_t SL_FSR_I = slot_t'(5);
    localparam slot_t SL_FAR_D = slot_t'(6);
    localparam slot_t SL_FAR_I = slot_t'(7);
    localparam slot_t SL_LCK_D = slot_t'(8);
    localparam slot_t SL_LCK_I = slot_t'(9);
    localparam slot_t SL_PID   = slot_t'(10);
    localparam slot_t SL_CTX   = slot_t'(11);

    typedef enum logic [3:0] {
        TG_NONE,
        TG_ID,
        TG_CTYPE,
        TG_ZERO,
        TG_AUX,
        TG_CACHEOP,
        TG_TLBOP,
        TG_STORED
    } tgt_e;

    typedef struct packed {
        tgt_e  tgt;
        logic  undef;
        logic  stored;
        slot_t slot;
    } dec_t;

    function automatic dec_t dec_undef();
        dec_t d;
        d.tgt    = TG_NONE;
        d.undef  = 1'b1;
        d.stored = 1'b0;
        d.slot   = '0;
        return d;
    endfunction

    function automatic dec_t dec_fixed(input tgt_e t);
        dec_t d;
        d.tgt    = t;
        d.undef  = 1'b0;
        d.stored = 1'b0;
        d.slot   = '0;
        return d;
    endfunction

    function automatic dec_t dec_slot(input slot_t s);
        dec_t d;
        d.tgt    = TG_STORED;
        d.undef  = 1'b0;
        d.stored = 1'b1;
        d.slot   = s;
        return d;
    endfunction

    // data copy at selector 0, instruction copy at selector 1
    function automatic dec_t dec_pair(input logic [SEL_W-1:0] sel,
                                      input slot_t s0, input slot_t s1);
        if (sel == SEL_W'(0)) return dec_slot(s0);
        if (sel == SEL_W'(1)) return dec_slot(s1);
        return dec_undef();
    endfunction

    function automatic dec_t decode_op(input logic [CRN_W-1:0] crn,
                                       input logic [SEL_W-1:0] sel,
                                       input logic             wr,
                                       input logic             aux_en);
        dec_t d;
        d = dec_undef();
        case (crn)
            4'd0: begin
                if (!wr) begin
                    if (sel == SEL_W'(1))      d = dec_fixed(TG_CTYPE);
                    else if (sel == SEL_W'(2)) d = dec_fixed(TG_ZERO);
                    else                       d = dec_fixed(TG_ID);
                end
            end
            4'd1: begin
                if (sel == SEL_W'(0))      d = dec_slot(SL_CTRL);
                else if (sel == SEL_W'(2)) d = dec_slot(SL_CPACC);
                else if (sel == SEL_W'(1) && aux_en && !wr)
                                           d = dec_fixed(TG_AUX);
            end
            4'd2:  d = dec_slot(SL_TTB);
            4'd3:  d = dec_slot(SL_DAC);
            4'd5:  d = dec_pair(sel, SL_FSR_D, SL_FSR_I);
            4'd6:  d = dec_pair(sel, SL_FAR_D, SL_FAR_I);
            4'd7:  d = dec_fixed(TG_CACHEOP);
            4'd8: begin
                if (wr && (sel == SEL_W'(0) || sel == SEL_W'(1)))
                    d = dec_fixed(TG_TLBOP);
            end
            4'd9:  d = dec_pair(sel, SL_LCK_D, SL_LCK_I);
            4'd10: d = dec_fixed(TG_ZERO);
            4'd13: d = dec_pair(sel, SL_PID, SL_CTX);
            4'd15: d = dec_fixed(TG_ZERO);
            default: d = dec_undef();
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int unsigned INSN_W  = 32,
    parameter int unsigned CRN_LSB = 16,
    parameter int unsigned SEL_LSB = 5
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [INSN_W-1:0] acc_insn,
    input  logic              aux_en,
    output dec_t              dec,
    output logic              undef,
    output logic              wr_commit,
    output logic              rd_active
);

    logic [CRN_W-1:0] crn;
    logic [SEL_W-1:0] sel;
    logic             insn_unused;

    assign crn         = acc_insn[CRN_LSB +: CRN_W];
    assign sel         = acc_insn[SEL_LSB +: SEL_W];
    assign insn_unused = ^acc_insn;

    always_comb begin
        dec       = decode_op(crn, sel, acc_write, aux_en);
        undef     = acc_valid && dec.undef;
        wr_commit = acc_valid && acc_write && !dec.undef;
        rd_active = acc_valid && !acc_write && !dec.undef;
    end

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
    import sysctl_pkg::*;
#(
    parameter int unsigned DW            = 32,
    parameter logic [31:0] MODEL0_CPU_ID = 32'h4100_A010,
    parameter logic [31:0] MODEL0_FP_ID  = 32'h4101_1090,
    parameter bit          MODEL0_AUX    = 1'b0,
    parameter logic [31:0] MODEL1_CPU_ID = 32'h4100_B020,
    parameter logic [31:0] MODEL1_FP_ID  = 32'h4101_10A0,
    parameter bit          MODEL1_AUX    = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          model_sel,
    input  logic          wr_commit,
    input  logic          rd_active,
    input  dec_t          dec,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] bank [N_SLOTS],
    output logic [DW-1:0] cpu_id,
    output logic [DW-1:0] fp_id,
    output logic          aux_en,
    output logic          tlb_flush,
    output logic          tcache_flush,
    output logic          flag_clr
);

    logic tlb_next;
    logic tc_next;
    logic flag_next;
    logic pid_changes;

    generate
        for (genvar gs = 0; gs < N_SLOTS; gs++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    bank[gs] <= '0;
                end else if (wr_commit && dec.stored && dec.slot == slot_t'(gs)) begin
                    bank[gs] <= wr_data;
                end
            end
        end
    endgenerate

    always_comb begin
        pid_changes = 1'b0;
        if (dec.stored && dec.slot == SL_PID) pid_changes = (wr_data != bank[SL_PID]);
        if (dec.stored && dec.slot == SL_CTX) pid_changes = (wr_data != bank[SL_CTX]);

        tlb_next  = wr_commit && ((dec.stored && dec.slot == SL_CTRL) ||
                                  (dec.tgt == TG_TLBOP) ||
                                  pid_changes);
        tc_next   = wr_commit && dec.stored && dec.slot == SL_CPACC;
        flag_next = rd_active && dec.tgt == TG_CACHEOP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_id       <= model_sel ? DW'(MODEL1_CPU_ID) : DW'(MODEL0_CPU_ID);
            fp_id        <= model_sel ? DW'(MODEL1_FP_ID)  : DW'(MODEL0_FP_ID);
            aux_en       <= model_sel ? MODEL1_AUX : MODEL0_AUX;
            tlb_flush    <= 1'b0;
            tcache_flush <= 1'b0;
            flag_clr     <= 1'b0;
        end else begin
            tlb_flush    <= tlb_next;
            tcache_flush <= tc_next;
            flag_clr     <= flag_next;
        end
    end

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
    import sysctl_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          rd_active,
    input  dec_t          dec,
    input  logic [DW-1:0] bank [N_SLOTS],
    input  logic [DW-1:0] cpu_id,
    output logic [DW-1:0] rd_data
);

    always_comb begin
        rd_data = '0;
        if (rd_active) begin
            case (dec.tgt)
                TG_ID:     rd_data = cpu_id;
                TG_CTYPE:  rd_data = DW'(CACHE_TYPE_WORD);
                TG_AUX:    rd_data = DW'(1);
                TG_STORED: rd_data = bank[dec.slot];
                default:   rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int unsigned INSN_W        = 32,
    parameter int unsigned DW            = 32,
    parameter int unsigned CRN_LSB       = 16,
    parameter int unsigned SEL_LSB       = 5,
    parameter logic [31:0] MODEL0_CPU_ID = 32'h4100_A010,
    parameter logic [31:0] MODEL0_FP_ID  = 32'h4101_1090,
    parameter bit          MODEL0_AUX    = 1'b0,
    parameter logic [31:0] MODEL1_CPU_ID = 32'h4100_B020,
    parameter logic [31:0] MODEL1_FP_ID  = 32'h4101_10A0,
    parameter bit          MODEL1_AUX    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              model_sel,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [INSN_W-1:0] acc_insn,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data,
    output logic              undef,
    output logic [DW-1:0]     fp_id,
    output logic              tlb_flush,
    output logic              tcache_flush,
    output logic              flag_clr
);

    dec_t          dec;
    logic          wr_commit;
    logic          rd_active;
    logic          aux_en;
    logic [DW-1:0] cpu_id;
    logic [DW-1:0] bank [N_SLOTS];

    sysctl_decode #(
        .INSN_W  (INSN_W),
        .CRN_LSB (CRN_LSB),
        .SEL_LSB (SEL_LSB)
    ) u_decode (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_insn  (acc_insn),
        .aux_en    (aux_en),
        .dec       (dec),
        .undef     (undef),
        .wr_commit (wr_commit),
        .rd_active (rd_active)
    );

    sysctl_store #(
        .DW            (DW),
        .MODEL0_CPU_ID (MODEL0_CPU_ID),
        .MODEL0_FP_ID  (MODEL0_FP_ID),
        .MODEL0_AUX    (MODEL0_AUX),
        .MODEL1_CPU_ID (MODEL1_CPU_ID),
        .MODEL1_FP_ID  (MODEL1_FP_ID),
        .MODEL1_AUX    (MODEL1_AUX)
    ) u_store (
        .clk          (clk),
        .rst          (rst),
        .model_sel    (model_sel),
        .wr_commit    (wr_commit),
        .rd_active    (rd_active),
        .dec          (dec),
        .wr_data      (wr_data),
        .bank         (bank),
        .cpu_id       (cpu_id),
        .fp_id        (fp_id),
        .aux_en       (aux_en),
        .tlb_flush    (tlb_flush),
        .tcache_flush (tcache_flush),
        .flag_clr     (flag_clr)
    );

    sysctl_rdmux #(
        .DW (DW)
    ) u_rdmux (
        .rd_active (rd_active),
        .dec       (dec),
        .bank      (bank),
        .cpu_id    (cpu_id),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk
    import sysctl_pkg::*;
#(
    parameter int unsigned INSN_W  = 32,
    parameter int unsigned DW      = 32,
    parameter int unsigned CRN_LSB = 16,
    parameter int unsigned SEL_LSB = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [INSN_W-1:0] acc_insn,
    input logic [DW-1:0]     rd_data,
    input logic              undef,
    input logic              tlb_flush,
    input logic              tcache_flush,
    input logic              flag_clr
);

    logic [CRN_W-1:0] c_crn;
    logic [SEL_W-1:0] c_sel;
    logic             chk_unused;
    logic             is_rd;
    logic             is_wr;

    assign c_crn      = acc_insn[CRN_LSB +: CRN_W];
    assign c_sel      = acc_insn[SEL_LSB +: SEL_W];
    assign chk_unused = ^acc_insn;
    assign is_rd      = acc_valid && !acc_write;
    assign is_wr      = acc_valid && acc_write;

    // R1
    p_ctype_word_r1: assert property (@(posedge clk) disable iff (rst)
        is_rd && c_crn == 4'd0 && c_sel == 3'd1 |-> !undef && rd_data == DW'(CACHE_TYPE_WORD));

    // R1
    p_id_write_undef_r1: assert property (@(posedge clk) disable iff (rst)
        is_wr && c_crn == 4'd0 |-> undef);

    // R4
    p_tcache_source_r4: assert property (@(posedge clk) disable iff (rst)
        tcache_flush |-> $past(is_wr && !undef && c_crn == 4'd1 && c_sel == 3'd2));

    // R7
    p_tlbop_read_undef_r7: assert property (@(posedge clk) disable iff (rst)
        is_rd && c_crn == 4'd8 |-> undef);

    // R9
    p_reserved_undef_r9: assert property (@(posedge clk) disable iff (rst)
        acc_valid && (c_crn == 4'd4 || c_crn == 4'd11 || c_crn == 4'd12 || c_crn == 4'd14)
        |-> undef);

    // R10
    p_zero_regs_r10: assert property (@(posedge clk) disable iff (rst)
        is_rd && (c_crn == 4'd10 || c_crn == 4'd15 || c_crn == 4'd7) |-> !undef && rd_data == '0);

    // R10
    p_flag_source_r10: assert property (@(posedge clk) disable iff (rst)
        flag_clr |-> $past(is_rd && c_crn == 4'd7));

    // R11
    p_undef_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        undef |=> !tlb_flush && !tcache_flush && !flag_clr);

    // R12
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> !undef && rd_data == '0);

endmodule

bind sysctl_regs sysctl_regs_chk #(
    .INSN_W  (INSN_W),
    .DW      (DW),
    .CRN_LSB (CRN_LSB),
    .SEL_LSB (SEL_LSB)
) u_chk (.*);

// File: tb/tb_sysctl_regs.sv
`timescale 1ns/1ps
module tb_sysctl_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        model_sel = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_insn = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        undef;
    logic [31:0] fp_id;
    logic        tlb_flush;
    logic        tcache_flush;
    logic        flag_clr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    localparam logic [31:0] ID_M0   = 32'h4100_A010;
    localparam logic [31:0] FP_M0   = 32'h4101_1090;
    localparam logic [31:0] ID_M1   = 32'h4100_B020;
    localparam logic [31:0] FP_M1   = 32'h4101_10A0;
    localparam logic [31:0] CTYPE   = 32'h01DD_20D2;
    localparam logic [31:0] BASE_A  = 32'hE000_0F10;
    localparam logic [31:0] BASE_B  = 32'h1FF0_F01F;

    always #2 clk = ~clk;

    sysctl_regs dut (
        .clk          (clk),
        .rst          (rst),
        .model_sel    (model_sel),
        .acc_valid    (acc_valid),
        .acc_write    (acc_write),
        .acc_insn     (acc_insn),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .undef        (undef),
        .fp_id        (fp_id),
        .tlb_flush    (tlb_flush),
        .tcache_flush (tcache_flush),
        .flag_clr     (flag_clr)
    );

    function automatic logic [31:0] mk(input logic [31:0] base, input int crn, input int sel);
        return base | (32'(crn) << 16) | (32'(sel) << 5);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic m);
        @(negedge clk);
        rst = 1'b1; model_sel = m; acc_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input int crn, input int sel, input logic [31:0] d,
                      output logic u, output logic t, output logic c);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_insn = mk(BASE_A, crn, sel); wr_data = d;
        #1 u = undef;
        @(posedge clk);
        #1 t = tlb_flush; c = tcache_flush;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd_b(input logic [31:0] base, input int crn, input int sel,
                        output logic [31:0] d, output logic u, output logic f);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_insn = mk(base, crn, sel);
        #1 d = rd_data; u = undef;
        @(posedge clk);
        #1 f = flag_clr;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic rd(input int crn, input int sel, output logic [31:0] d, output logic u);
        logic f;
        rd_b(BASE_A, crn, sel, d, u, f);
    endtask

    task automatic t_reset_m0();
        logic [31:0] d; logic u;
        do_reset(1'b0);
        #1;
        chk(fp_id == FP_M0, "R2 fp id model0", fp_id, FP_M0);
        chk(!tlb_flush && !tcache_flush && !flag_clr, "R2 pulses low",
            {tlb_flush, tcache_flush, flag_clr}, 0);
        chk(!undef && rd_data == 0, "R12 idle outputs", {undef, rd_data[30:0]}, 0);
        rd(1, 0, d, u);
        chk(d == 0 && !u, "R2 control cleared", d, 0);
        rd(13, 1, d, u);
        chk(d == 0 && !u, "R2 context cleared", d, 0);
    endtask

    task automatic t_ident();
        logic [31:0] d; logic u, t, c;
        rd(0, 0, d, u);
        chk(d == ID_M0 && !u, "R1 cpu id sel0", d, ID_M0);
        rd(0, 1, d, u);
        chk(d == CTYPE && !u, "R1 cache type", d, CTYPE);
        rd(0, 2, d, u);
        chk(d == 0 && !u, "R1 tcm status", d, 0);
        rd(0, 6, d, u);
        chk(d == ID_M0 && !u, "R1 cpu id sel6", d, ID_M0);
        wr(0, 0, 32'h1234_5678, u, t, c);
        chk(u && !t && !c, "R1 write undef", {u, t, c}, 3'b100);
        rd(0, 0, d, u);
        chk(d == ID_M0, "R1 id unchanged", d, ID_M0);
    endtask

    task automatic t_sysreg();
        logic [31:0] d; logic u, t, c;
        wr(1, 0, 32'h0000_2005, u, t, c);
        chk(!u && t && !c, "R4 control write tlb pulse", {u, t, c}, 3'b010);
        @(posedge clk); #1;
        chk(!tlb_flush, "R4 tlb pulse one cycle", tlb_flush, 0);
        rd(1, 0, d, u);
        chk(d == 32'h0000_2005 && !u, "R3 control readback", d, 32'h0000_2005);
        wr(1, 2, 32'h00F0_0000, u, t, c);
        chk(!u && !t && c, "R4 cpacc write tcache pulse", {u, t, c}, 3'b001);
        @(posedge clk); #1;
        chk(!tcache_flush, "R4 tcache pulse one cycle", tcache_flush, 0);
        rd(1, 2, d, u);
        chk(d == 32'h00F0_0000 && !u, "R3 cpacc readback", d, 32'h00F0_0000);
        rd(1, 1, d, u);
        chk(u, "R3 aux undef on model0", u, 1);
        rd(1, 5, d, u);
        chk(u, "R3 reg1 sel5 undef", u, 1);
    endtask

    task automatic t_tables();
        logic [31:0] d; logic u, t, c;
        wr(2, 4, 32'hABCD_C000, u, t, c);
        chk(!u && !t && !c, "R5 reg2 write", {u, t, c}, 0);
        rd(2, 0, d, u);
        chk(d == 32'hABCD_C000 && !u, "R5 reg2 other selector", d, 32'hABCD_C000);
        wr(3, 0, 32'h5555_0003, u, t, c);
        rd(3, 7, d, u);
        chk(d == 32'h5555_0003 && !u, "R5 reg3 other selector", d, 32'h5555_0003);
    endtask

    task automatic t_pairs();
        logic [31:0] d; logic u, t, c;
        for (int k = 0; k < 3; k++) begin
            int n;
            n = (k == 0) ? 5 : (k == 1) ? 6 : 9;
            wr(n, 0, 32'h1000_0000 + 32'(n), u, t, c);
            wr(n, 1, 32'h2000_0000 + 32'(n), u, t, c);
            rd(n, 0, d, u);
            chk(d == 32'h1000_0000 + 32'(n) && !u, "R6 data copy", d, 32'h1000_0000 + 32'(n));
            rd(n, 1, d, u);
            chk(d == 32'h2000_0000 + 32'(n) && !u, "R6 instr copy", d, 32'h2000_0000 + 32'(n));
            rd(n, 2, d, u);
            chk(u, "R6 sel2 undef", u, 1);
        end
    endtask

    task automatic t_tlbop();
        logic [31:0] d; logic u, t, c;
        wr(8, 0, 32'h0, u, t, c);
        chk(!u && t, "R7 tlb op sel0", {u, t}, 2'b01);
        wr(8, 1, 32'hFFFF_F000, u, t, c);
        chk(!u && t, "R7 tlb op sel1", {u, t}, 2'b01);
        wr(8, 2, 32'h0, u, t, c);
        chk(u && !t, "R7 tlb op sel2 undef", {u, t}, 2'b10);
        rd(8, 0, d, u);
        chk(u, "R7 read undef", u, 1);
    endtask

    task automatic t_ctx();
        logic [31:0] d; logic u, t, c;
        wr(13, 0, 32'h0, u, t, c);
        chk(!u && !t, "R8 same relocation no flush", {u, t}, 0);
        wr(13, 0, 32'h0200_0000, u, t, c);
        chk(!u && t, "R8 new relocation flush", {u, t}, 2'b01);
        wr(13, 1, 32'h55, u, t, c);
        chk(!u && t, "R8 new context flush", {u, t}, 2'b01);
        wr(13, 1, 32'h55, u, t, c);
        chk(!u && !t, "R8 same context no flush", {u, t}, 0);
        rd(13, 0, d, u);
        chk(d == 32'h0200_0000, "R8 relocation readback", d, 32'h0200_0000);
        rd(13, 1, d, u);
        chk(d == 32'h55, "R8 context readback", d, 32'h55);
        rd(13, 3, d, u);
        chk(u, "R8 sel3 undef", u, 1);
    endtask

    task automatic t_reserved();
        logic [31:0] d; logic u, t, c;
        for (int k = 0; k < 4; k++) begin
            int n;
            n = (k == 0) ? 4 : (k == 1) ? 11 : (k == 2) ? 12 : 14;
            rd(n, 0, d, u);
            chk(u, "R9 reserved read undef", u, 1);
            wr(n, 0, 32'hFFFF_FFFF, u, t, c);
            chk(u && !t && !c, "R9 reserved write undef", {u, t, c}, 3'b100);
        end
    endtask

    task automatic t_quiet();
        logic [31:0] d; logic u, t, c, f;
        wr(10, 0, 32'hDEAD_BEEF, u, t, c);
        chk(!u && !t && !c, "R10 reg10 write ignored", {u, t, c}, 0);
        rd(10, 0, d, u);
        chk(d == 0 && !u, "R10 reg10 reads zero", d, 0);
        wr(15, 3, 32'hDEAD_BEEF, u, t, c);
        rd(15, 3, d, u);
        chk(d == 0 && !u, "R10 reg15 reads zero", d, 0);
        wr(7, 0, 32'hCAFE_0000, u, t, c);
        chk(!u && !t && !c, "R10 reg7 write ignored", {u, t, c}, 0);
        rd_b(BASE_A, 7, 5, d, u, f);
        chk(d == 0 && !u && f, "R10 reg7 read flag clear", {d[29:0], u, f}, 1);
        @(posedge clk); #1;
        chk(!flag_clr, "R10 flag clear one cycle", flag_clr, 0);
    endtask

    task automatic t_undef_state();
        logic [31:0] d; logic u, t, c;
        wr(5, 3, 32'h9999_9999, u, t, c);
        chk(u && !t && !c, "R11 bad selector write", {u, t, c}, 3'b100);
        rd(5, 0, d, u);
        chk(d == 32'h1000_0005, "R11 data copy unchanged", d, 32'h1000_0005);
        rd(5, 1, d, u);
        chk(d == 32'h2000_0005, "R11 instr copy unchanged", d, 32'h2000_0005);
        wr(1, 1, 32'h7777_7777, u, t, c);
        chk(u && !t && !c, "R11 aux write undef", {u, t, c}, 3'b100);
        rd(1, 0, d, u);
        chk(d == 32'h0000_2005, "R11 control unchanged", d, 32'h0000_2005);
    endtask

    task automatic t_fields();
        logic [31:0] d; logic u, f;
        rd_b(BASE_B, 3, 0, d, u, f);
        chk(d == 32'h5555_0003 && !u, "R12 noisy insn bits", d, 32'h5555_0003);
        rd_b(BASE_B, 0, 1, d, u, f);
        chk(d == CTYPE && !u, "R12 noisy id decode", d, CTYPE);
    endtask

    task automatic t_model1();
        logic [31:0] d; logic u;
        do_reset(1'b1);
        #1;
        chk(fp_id == FP_M1, "R2 fp id model1", fp_id, FP_M1);
        rd(0, 0, d, u);
        chk(d == ID_M1, "R2 cpu id model1", d, ID_M1);
        rd(1, 1, d, u);
        chk(d == 32'h1 && !u, "R3 aux reads one", d, 1);
        rd(2, 0, d, u);
        chk(d == 0, "R2 reg2 cleared", d, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_m0();
        t_ident();
        t_sysreg();
        t_tables();
        t_pairs();
        t_tlbop();
        t_ctx();
        t_reserved();
        t_quiet();
        t_undef_state();
        t_fields();
        t_model1();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule